// File: doc/BRIEF.md
# MIDI UART-Mode Command Port

This block is a byte-wide host port that presents a MIDI byte stream to software through two addresses: offset 0 is the data register, and offset 1 is written as a command register and read as a status register. Only the minimal UART-style subset of the classic MIDI interface is provided. A reset command and an enter-UART command are honoured. Any other command byte is dropped without effect. Each accepted command is answered with an acknowledge byte that software reads back from the data register.

Outgoing bytes written by the host are buffered in a 16-entry transmit FIFO and offered on a valid/ready stream toward a serial shifter. Incoming MIDI bytes arrive on a second valid/ready stream, are buffered in a 16-entry receive FIFO, and are read by the host from the data register. Two level outputs, each gated by its own enable input, tell an interrupt controller that the transmit side has drained or that receive data is waiting. The serial shifter itself lies outside this block.

Top module: `midi_cmd_port`

## Requirements
- R1: After reset the status register reads 0x80, tx_valid is 0 and rx_ready is 0, because the port starts outside UART mode.
- R2: Writing 0x3F to offset 1 enters UART mode and queues one acknowledge byte 0xFE into the receive FIFO. The status then reads bit 7 = 0, and a data read returns 0xFE.
- R3: Writing 0xFF to offset 1 empties both FIFOs, leaves UART mode and queues one 0xFE acknowledge, which is then the only byte waiting.
- R4: A command write of any value other than 0xFF or 0x3F changes neither the mode nor the FIFOs and queues no acknowledge.
- R5: In UART mode, data written to offset 0 appears on tx_data in write order, and each byte is held stable until tx_ready accepts it. Data writes made outside UART mode are dropped.
- R6: Status bit 6 reads 1 exactly when the transmit FIFO holds 16 bytes. Any write to either offset made while it is 1 is discarded.
- R7: rx_ready is 1 only in UART mode while the receive FIFO has room. Accepted bytes are read back from offset 0 in arrival order. Status bit 7 reads 0 while any byte is waiting.
- R8: In a cycle in which a command is accepted, rx_ready is 0. The acknowledge therefore sits ahead of any MIDI byte that arrives later.
- R9: A read of offset 0 while the receive FIFO is empty returns the last byte previously taken from that FIFO.
- R10: irq_tx equals irq_tx_en AND (transmit FIFO empty). irq_rx equals irq_rx_en AND (receive FIFO not empty).
- R11: host_rdata is registered. It takes its new value on the clock edge that samples host_rd and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | 0 = data register, 1 = command/status register |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Shifter takes the transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received MIDI byte offered |
| rx_ready | output | 1 | Port accepts the received byte |
| rx_data | input | 8 | Received MIDI byte |
| irq_tx_en | input | 1 | Enable for the transmit-empty event |
| irq_rx_en | input | 1 | Enable for the receive-available event |
| irq_tx | output | 1 | Transmit FIFO empty event |
| irq_rx | output | 1 | Receive data waiting event |

## Verification
The hardest case to reach from the ports is a command accepted in the same cycle that the MIDI stream offers a byte. The bench raises host_wr with 0x3F and rx_valid in the same cycle, checks that rx_ready is held low, and then checks that the acknowledge is read before the MIDI byte. A second hard case is a full transmit FIFO. The bench holds tx_ready low through sixteen writes, then tries a further data write and a command write, and confirms that neither leaves a trace before the drained stream is compared against the scoreboard.

// File: rtl/mpu_port_pkg.sv
// Package: shared command codes and sizes for the MIDI command port.
// Assumes byte-wide host and stream paths.
package mpu_port_pkg;
    localparam int unsigned BYTE_W      = 8;
    localparam logic [7:0]  CMD_RESET   = 8'hFF;
    localparam logic [7:0]  CMD_UART_ON = 8'h3F;
    localparam logic [7:0]  ACK_BYTE    = 8'hFE;
endpackage

// File: rtl/port_byte_fifo.sv
// Module: port_byte_fifo
// Circular FIFO with a flush input. When flush and push are asserted together,
// the FIFO is emptied and then holds only the pushed entry.
// Assumes DEPTH is a power of two and that the caller never pushes into a full FIFO
// unless it pops or flushes in the same cycle.
module port_byte_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr, wr_ptr;
    logic [AW:0]      cnt;
    logic             do_pop;

    assign do_pop = pop && !empty;
    assign empty  = (cnt == '0);
    assign full   = (cnt == FULL_CNT);
    assign head   = mem[rd_ptr];

    // Storage write; a flush restarts writing at slot zero.
    always_ff @(posedge clk) begin
        if (push) mem[flush ? '0 : wr_ptr] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= push ? AW'(1) : '0;
            cnt    <= push ? (AW+1)'(1) : '0;
        end else begin
            if (push)   wr_ptr <= wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + (AW+1)'(push) - (AW+1)'(do_pop);
        end
    end

    // R6: occupancy never exceeds the depth
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);
    // R6: the writer never pushes into a full FIFO without making room
    p_push_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !flush) |-> pop);
endmodule

// File: rtl/port_cmd_decode.sv
// Module: port_cmd_decode
// Decodes host writes into data pushes, flush and acknowledge requests,
// and holds the UART-mode flag. Assumes tx_full is the transmit FIFO full flag;
// every write is refused while it is set.
module port_cmd_decode
    import mpu_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_sel,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    input  logic        tx_full,
    output logic        uart_mode,
    output logic        tx_push,
    output logic        flush,
    output logic        ack_req
);
    logic wr_ok, cmd_rst, cmd_uart;

    assign wr_ok    = host_wr && !tx_full;
    assign cmd_rst  = wr_ok && host_sel && (host_wdata == CMD_RESET);
    assign cmd_uart = wr_ok && host_sel && (host_wdata == CMD_UART_ON);
    assign tx_push  = wr_ok && !host_sel && uart_mode;
    assign flush    = cmd_rst;
    assign ack_req  = cmd_rst || cmd_uart;

    // Mode flag: the reset command clears it, the enter command sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)        uart_mode <= 1'b0;
        else if (cmd_rst)  uart_mode <= 1'b0;
        else if (cmd_uart) uart_mode <= 1'b1;
    end

    // R4: an unknown command leaves the mode unchanged
    p_ignore_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel && host_wdata != CMD_RESET && host_wdata != CMD_UART_ON)
        |=> $stable(uart_mode));
endmodule

// File: rtl/midi_cmd_port.sv
// Module: midi_cmd_port
// Host command/data port with transmit and receive FIFOs, acknowledge
// insertion, active-low status flags and gated event outputs.
// Assumes a single clock, a synchronous reset and one host access per cycle.
module midi_cmd_port
    import mpu_port_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_sel,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic [7:0] tx_data,
    input  logic       rx_valid,
    output logic       rx_ready,
    input  logic [7:0] rx_data,
    input  logic       irq_tx_en,
    input  logic       irq_rx_en,
    output logic       irq_tx,
    output logic       irq_rx
);
    logic       uart_mode, tx_push, flush, ack_req;
    logic       tx_empty, tx_full, rx_empty, rx_full;
    logic       ack_push, rx_push, rx_pop;
    logic [7:0] rx_head, rx_in, last_q, rdata_q, status;

    port_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_wdata(host_wdata), .tx_full(tx_full), .uart_mode(uart_mode),
        .tx_push(tx_push), .flush(flush), .ack_req(ack_req)
    );

    port_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(tx_push),
        .push_data(host_wdata), .pop(tx_ready), .head(tx_data),
        .empty(tx_empty), .full(tx_full)
    );

    // An acknowledge takes precedence over the stream; after a flush there is always room.
    assign ack_push = ack_req && (flush || !rx_full);
    assign rx_ready = uart_mode && !rx_full && !ack_req;
    assign rx_push  = ack_push || (rx_valid && rx_ready);
    assign rx_in    = ack_push ? ACK_BYTE : rx_data;
    assign rx_pop   = host_rd && !host_sel && !flush;

    port_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(rx_push),
        .push_data(rx_in), .pop(rx_pop), .head(rx_head),
        .empty(rx_empty), .full(rx_full)
    );

    assign tx_valid   = !tx_empty;
    assign status     = {rx_empty, tx_full, 6'b0};
    assign host_rdata = rdata_q;
    assign irq_tx     = irq_tx_en && tx_empty;
    assign irq_rx     = irq_rx_en && !rx_empty;

    // Read register: status, the receive head, or the repeated last byte when empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            last_q  <= '0;
        end else if (host_rd) begin
            if (host_sel) begin
                rdata_q <= status;
            end else if (!rx_empty) begin
                rdata_q <= rx_head;
                last_q  <= rx_head;
            end else begin
                rdata_q <= last_q;
            end
        end
    end

    // R5: a byte that is offered and not taken stays stable
    p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !flush) |=> (tx_valid && $stable(tx_data)));
    // R3: a reset command leaves the transmit side empty
    p_reset_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel && host_wdata == CMD_RESET && !tx_full) |=> !tx_valid);
    // R2: an enter command leaves a byte waiting for the host
    p_enter_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel && host_wdata == CMD_UART_ON && !tx_full && !rx_full) |=> irq_rx || !irq_rx_en);
    // R8: the stream is held off while a command is accepted
    p_ack_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel && !tx_full &&
         (host_wdata == CMD_RESET || host_wdata == CMD_UART_ON)) |-> !rx_ready);
endmodule

// File: tb/sim_midi_cmd_port.sv
module sim_midi_cmd_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       tx_valid, tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic       rx_valid = 1'b0, rx_ready;
    logic [7:0] rx_data = '0;
    logic       irq_tx_en = 1'b1, irq_rx_en = 1'b1, irq_tx, irq_rx;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_tx [$];
    logic [7:0] exp_rx [$];

    always #4 clk = ~clk;   // 125 MHz

    midi_cmd_port u0 (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .irq_tx_en(irq_tx_en), .irq_rx_en(irq_rx_en), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic sel, output logic [7:0] v);
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    // Driver: push the expected byte when the port takes it.
    task automatic send_rx(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        for (int i = 0; i < 50; i++) begin
            #2;
            if (rx_ready) begin
                exp_rx.push_back(b);
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        rx_valid = 1'b0;
    endtask

    task automatic read_expect(input string req);
        logic [7:0] v, e;
        e = exp_rx.pop_front();
        host_read(1'b0, v);
        check(v == e, req, v, e);
    endtask

    // Monitor: compare each transmit handshake against the scoreboard.
    always begin
        @(negedge clk);
        #2;
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) check(1'b0, "R5 unexpected tx", tx_data, 0);
            else begin
                logic [7:0] e;
                e = exp_tx.pop_front();
                check(tx_data == e, "R5 tx order", tx_data, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        host_read(1'b1, v);
        check(v == 8'h80, "R1 status", v, 8'h80);
        check(!tx_valid && !rx_ready, "R1 idle stream", {tx_valid, rx_ready}, 0);
        check(irq_tx && !irq_rx, "R10 irq after reset", {irq_tx, irq_rx}, 2);

        // R5 data dropped outside UART mode
        host_write(1'b0, 8'h55);
        check(!tx_valid, "R5 dropped outside mode", tx_valid, 0);

        // R4 unknown command
        host_write(1'b1, 8'h12);
        host_read(1'b1, v);
        check(v == 8'h80, "R4 no ack", v, 8'h80);
        check(!rx_ready, "R4 mode unchanged", rx_ready, 0);

        // R2 enter UART mode
        host_write(1'b1, 8'h3F);
        host_read(1'b1, v);
        check(v == 8'h00, "R2 status ack waiting", v, 8'h00);
        exp_rx.push_back(8'hFE);
        read_expect("R2 ack byte");
        // R11 value held across idle cycles
        repeat (3) @(negedge clk);
        check(host_rdata == 8'hFE, "R11 read data held", host_rdata, 8'hFE);
        host_read(1'b1, v);
        check(v == 8'h80, "R2 status drained", v, 8'h80);

        // R6 fill the transmit FIFO
        tx_ready = 1'b0;
        for (int i = 0; i < 16; i++) begin
            host_write(1'b0, 8'(8'h20 + i));
            exp_tx.push_back(8'(8'h20 + i));
        end
        host_read(1'b1, v);
        check(v == 8'hC0, "R6 full flag", v, 8'hC0);
        check(!irq_tx, "R10 irq_tx while full", irq_tx, 0);
        host_write(1'b0, 8'h99);
        host_write(1'b1, 8'h3F);
        host_read(1'b1, v);
        check(v == 8'hC0, "R6 writes discarded", v, 8'hC0);
        @(negedge clk);
        tx_ready = 1'b1;
        repeat (24) @(negedge clk);
        check(exp_tx.size() == 0, "R5 all bytes sent", exp_tx.size(), 0);
        check(!tx_valid && irq_tx, "R10 irq_tx drained", {tx_valid, irq_tx}, 1);

        // R7 receive path and full receive FIFO
        for (int i = 0; i < 16; i++) send_rx(8'(8'h60 + i));
        @(negedge clk);
        check(!rx_ready, "R7 rx full holds off", rx_ready, 0);
        check(irq_rx, "R10 irq_rx waiting", irq_rx, 1);
        irq_rx_en = 1'b0;
        @(negedge clk);
        check(!irq_rx, "R10 irq_rx gated", irq_rx, 0);
        irq_rx_en = 1'b1;
        host_read(1'b1, v);
        check(v == 8'h00, "R7 status bit7 low", v, 8'h00);
        for (int i = 0; i < 16; i++) read_expect("R7 rx order");
        host_read(1'b0, v);
        check(v == 8'h6F, "R9 empty read repeats", v, 8'h6F);
        host_read(1'b1, v);
        check(v == 8'h80, "R7 status empty", v, 8'h80);

        // R8 command and stream byte in the same cycle
        @(negedge clk);
        host_sel = 1'b1; host_wdata = 8'h3F; host_wr = 1'b1;
        rx_valid = 1'b1; rx_data = 8'h42;
        #2;
        check(!rx_ready, "R8 stream held off", rx_ready, 0);
        @(negedge clk);
        host_wr = 1'b0;
        #2;
        check(rx_ready, "R8 stream released", rx_ready, 1);
        @(negedge clk);
        rx_valid = 1'b0;
        exp_rx.push_back(8'hFE);
        exp_rx.push_back(8'h42);
        read_expect("R8 ack first");
        read_expect("R8 midi after ack");

        // R3 reset command flushes both sides
        tx_ready = 1'b0;
        host_write(1'b0, 8'hA1);
        host_write(1'b0, 8'hA2);
        send_rx(8'h77);
        exp_rx.delete();
        host_write(1'b1, 8'hFF);
        check(!tx_valid && !rx_ready, "R3 flushed and out of mode", {tx_valid, rx_ready}, 0);
        host_read(1'b1, v);
        check(v == 8'h00, "R3 ack waiting", v, 8'h00);
        exp_rx.push_back(8'hFE);
        read_expect("R3 only ack");
        host_read(1'b1, v);
        check(v == 8'h80, "R3 nothing else", v, 8'h80);
        host_write(1'b0, 8'h33);
        check(!tx_valid, "R5 dropped after reset cmd", tx_valid, 0);

        repeat (4) @(negedge clk);
        check(exp_tx.size() == 0, "R5 scoreboard empty", exp_tx.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule